// File: doc/BRIEF.md
# Halt-Mode Program Counter and Status Keeper

This block owns the program counter and the status word of a small 32-bit core for as long as that core is halted for debug. When a halt request of a supported kind arrives, the block records where the core stopped and freezes that value. It then offers a PC read value that carries a fixed pipeline offset. The offset is 8 if the core was running its full-width instruction set and 4 if it was running its compact instruction set. A vector-catch halt takes the vector address as its base. Every other kind takes the address where execution would resume.

While the core is halted, the debugger can write the PC or the status word, and it can force instructions that write the PC with a condition that passes or fails. The block tracks whether the PC read value and the restart address are still defined. An undefined value is driven as 32'hDEADBEEF and its valid flag is held low. When the debugger releases the core, the block presents the restart address together with its valid flag and a one-cycle release pulse. It then clears its tracking and waits for the next halt.

Top module: `dbg_pc_ctrl`

## Requirements
- R1: During and right after a synchronous reset, halted, pc_rd_ok, resume_ok and resume_go are 0, pc_rd_data and resume_addr are 32'hDEADBEEF, and status_rd is 0.
- R2: halt_req while running, with entry_kind 1 (external request), 2 (entry command), 3 (OS unlock) or 4 (cross trigger), sets halted on the next cycle. In that same cycle pc_rd_data equals entry_ret_addr plus 8 when prev_compact=0, or plus 4 when prev_compact=1, and pc_rd_ok is 1.
- R3: entry_kind 0 (vector catch) uses entry_vec_addr as the base instead, with the same offsets. Kinds 5 to 7 leave the block running and change no output.
- R4: While halted, pc_rd_data and pc_rd_ok hold their values in any cycle that has no PC write, no forced PC write, no status write and no restart.
- R5: A debugger PC write makes pc_rd_ok 0 and pc_rd_data 32'hDEADBEEF from the next cycle. A later restart with no further write gives resume_addr equal to the written value and resume_ok 1.
- R6: A restart with no PC write since the halt gives resume_ok 0 and resume_addr 32'hDEADBEEF.
- R7: A status write while halted appears on status_rd the next cycle. It makes the PC read undefined, and it makes the restart address undefined unless a PC write follows it.
- R8: A forced PC write whose condition passes acts like a debugger PC write with its own data. One whose condition fails leaves both the PC read and the restart address undefined, even after an earlier PC write.
- R9: While halted, status_rd changes only on a status write. While running, status_rd follows run_status with one cycle of delay and is captured at the halt.
- R10: restart_req while halted clears halted and pc_rd_ok on the next cycle and pulses resume_go for exactly one cycle. resume_addr and resume_ok hold until the next restart. The next halt recaptures the address.
- R11: Write and restart strobes while running are ignored, and halt_req while halted is ignored. Within one halted cycle the writes take effect in this order: status, then debugger PC, then forced PC. A restart in that same cycle uses the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request strobe |
| entry_kind | input | 3 | Halt cause: 0 vector catch, 1 external, 2 command, 3 OS unlock, 4 cross trigger |
| prev_compact | input | 1 | Core was in compact instruction state when halted |
| entry_ret_addr | input | 32 | Resume address of the halted core |
| entry_vec_addr | input | 32 | Vector address for a vector-catch halt |
| run_status | input | 32 | Status word of the running core |
| dbg_pc_wr | input | 1 | Debugger PC write strobe |
| dbg_pc_data | input | 32 | Debugger PC write value |
| dbg_st_wr | input | 1 | Debugger status write strobe |
| dbg_st_data | input | 32 | Debugger status write value |
| fpc_wr | input | 1 | Forced instruction writes the PC |
| fpc_cond_ok | input | 1 | Forced instruction passed its condition |
| fpc_data | input | 32 | PC value of the forced instruction |
| restart_req | input | 1 | Release the core |
| halted | output | 1 | Core is held in debug state |
| pc_rd_data | output | 32 | PC read value, or 32'hDEADBEEF when undefined |
| pc_rd_ok | output | 1 | PC read value is defined |
| status_rd | output | 32 | Status word read value |
| resume_addr | output | 32 | Restart address, or 32'hDEADBEEF when undefined |
| resume_ok | output | 1 | Restart address is defined |
| resume_go | output | 1 | One-cycle pulse on release |

## Verification
The risky overlap happens when several writes land in the same cycle as the release. Examples are a status write, a PC write and restart_req together, or a PC write, a failing forced write and restart_req together. The bench drives these combinations in a single cycle. It judges resume_addr and resume_ok against a model that applies the writes in the stated order before it launches. A halt_req that arrives while already halted, and strobes that arrive while running, are also sent between legal events, and the outputs must stay as the model predicts.

// File: rtl/dbg_pc_pkg.sv
package dbg_pc_pkg;
  // Tracking of what the debugger may still rely on while halted
  typedef enum logic [1:0] {
    TRK_RUN   = 2'd0,  // core running, nothing tracked
    TRK_FRESH = 2'd1,  // PC read defined, restart address not
    TRK_PCSET = 2'd2,  // restart address defined, PC read not
    TRK_UNDEF = 2'd3   // neither defined
  } trk_e;
endpackage

// File: rtl/dbg_pc_track.sv
module dbg_pc_track
  import dbg_pc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic kind_ok,
  input  logic st_wr,
  input  logic pc_wr,
  input  logic fpc_wr,
  input  logic fpc_ok,
  input  logic restart_req,
  output trk_e state_q,
  output trk_e state_eff,
  output trk_e state_nxt
);
  always_comb begin
    state_eff = state_q;
    if (state_q != TRK_RUN) begin
      if (st_wr)  state_eff = TRK_UNDEF;
      if (pc_wr)  state_eff = TRK_PCSET;
      if (fpc_wr) state_eff = fpc_ok ? TRK_PCSET : TRK_UNDEF;
    end
  end

  always_comb begin
    if (state_q == TRK_RUN)
      state_nxt = (halt_req && kind_ok) ? TRK_FRESH : TRK_RUN;
    else if (restart_req)
      state_nxt = TRK_RUN;
    else
      state_nxt = state_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TRK_RUN;
    else     state_q <= state_nxt;
  end

  AST_BAD_KIND_STAYS_RUN: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_RUN && !(halt_req && kind_ok)) |=> state_q == TRK_RUN); // R3
  AST_ENTRY_FRESH: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_RUN && halt_req && kind_ok) |=> state_q == TRK_FRESH); // R2
  AST_FAIL_LEAVES_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (state_q != TRK_RUN && fpc_wr && !fpc_ok && !restart_req) |=> state_q == TRK_UNDEF); // R8
endmodule

// File: rtl/dbg_pc_hold.sv
module dbg_pc_hold #(
  parameter int ADDR_W   = 32,
  parameter int FULL_OFS = 8,
  parameter int CMP_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic              entry,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              prev_compact,
  input  logic              pc_wr,
  input  logic [ADDR_W-1:0] pc_wr_data,
  input  logic              fpc_wr,
  input  logic              fpc_ok,
  input  logic [ADDR_W-1:0] fpc_data,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_eff,
  output logic [ADDR_W-1:0] pc_nxt
);
  localparam logic [ADDR_W-1:0] FULL_INC = ADDR_W'(FULL_OFS);
  localparam logic [ADDR_W-1:0] CMP_INC  = ADDR_W'(CMP_OFS);

  always_comb begin
    pc_eff = pc_q;
    if (!running) begin
      if (pc_wr)           pc_eff = pc_wr_data;
      if (fpc_wr && fpc_ok) pc_eff = fpc_data;
    end
  end

  always_comb begin
    if (running)
      pc_nxt = entry ? base_addr + (prev_compact ? CMP_INC : FULL_INC) : pc_q;
    else
      pc_nxt = pc_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!running && !pc_wr && !(fpc_wr && fpc_ok)) |=> $stable(pc_q)); // R4
endmodule

// File: rtl/dbg_status_hold.sv
module dbg_status_hold #(
  parameter int ST_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halted,
  input  logic            st_wr,
  input  logic [ST_W-1:0] st_wr_data,
  input  logic [ST_W-1:0] run_status,
  output logic [ST_W-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst)          st_q <= '0;
    else if (!halted) st_q <= run_status;
    else if (st_wr)   st_q <= st_wr_data;
  end

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted && !st_wr) |=> $stable(st_q)); // R9
  AST_STATUS_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (halted && st_wr) |=> st_q == $past(st_wr_data)); // R7
endmodule

// File: rtl/dbg_pc_ctrl.sv
module dbg_pc_ctrl
  import dbg_pc_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              ST_W      = 32,
  parameter int              KIND_W    = 3,
  parameter int              NUM_KINDS = 5,
  parameter int              KIND_VEC  = 0,
  parameter int              FULL_OFS  = 8,
  parameter int              CMP_OFS   = 4,
  parameter logic [ADDR_W-1:0] UNDEF_PAT = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [KIND_W-1:0] entry_kind,
  input  logic              prev_compact,
  input  logic [ADDR_W-1:0] entry_ret_addr,
  input  logic [ADDR_W-1:0] entry_vec_addr,
  input  logic [ST_W-1:0]   run_status,
  input  logic              dbg_pc_wr,
  input  logic [ADDR_W-1:0] dbg_pc_data,
  input  logic              dbg_st_wr,
  input  logic [ST_W-1:0]   dbg_st_data,
  input  logic              fpc_wr,
  input  logic              fpc_cond_ok,
  input  logic [ADDR_W-1:0] fpc_data,
  input  logic              restart_req,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_rd_data,
  output logic              pc_rd_ok,
  output logic [ST_W-1:0]   status_rd,
  output logic [ADDR_W-1:0] resume_addr,
  output logic              resume_ok,
  output logic              resume_go
);
  localparam logic [KIND_W-1:0] VEC_CODE = KIND_W'(KIND_VEC);

  logic              kind_ok;
  logic              running;
  logic              entry;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] pc_q, pc_eff, pc_nxt;
  trk_e              st_q, st_eff, st_nxt;

  generate
    if (NUM_KINDS >= (1 << KIND_W)) begin : g_all_kinds
      assign kind_ok = 1'b1;
    end else begin : g_some_kinds
      localparam logic [KIND_W-1:0] KIND_LIM = KIND_W'(NUM_KINDS);
      assign kind_ok = entry_kind < KIND_LIM;
    end
  endgenerate

  assign running   = (st_q == TRK_RUN);
  assign entry     = running && halt_req && kind_ok;
  assign base_addr = (entry_kind == VEC_CODE) ? entry_vec_addr : entry_ret_addr;
  assign halted    = !running;

  dbg_pc_track u_track (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .kind_ok    (kind_ok),
    .st_wr      (dbg_st_wr),
    .pc_wr      (dbg_pc_wr),
    .fpc_wr     (fpc_wr),
    .fpc_ok     (fpc_cond_ok),
    .restart_req(restart_req),
    .state_q    (st_q),
    .state_eff  (st_eff),
    .state_nxt  (st_nxt)
  );

  dbg_pc_hold #(
    .ADDR_W  (ADDR_W),
    .FULL_OFS(FULL_OFS),
    .CMP_OFS (CMP_OFS)
  ) u_hold (
    .clk         (clk),
    .rst         (rst),
    .running     (running),
    .entry       (entry),
    .base_addr   (base_addr),
    .prev_compact(prev_compact),
    .pc_wr       (dbg_pc_wr),
    .pc_wr_data  (dbg_pc_data),
    .fpc_wr      (fpc_wr),
    .fpc_ok      (fpc_cond_ok),
    .fpc_data    (fpc_data),
    .pc_q        (pc_q),
    .pc_eff      (pc_eff),
    .pc_nxt      (pc_nxt)
  );

  dbg_status_hold #(
    .ST_W(ST_W)
  ) u_status (
    .clk       (clk),
    .rst       (rst),
    .halted    (halted),
    .st_wr     (dbg_st_wr),
    .st_wr_data(dbg_st_data),
    .run_status(run_status),
    .st_q      (status_rd)
  );

  // Registered read and launch outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_rd_data  <= UNDEF_PAT;
      pc_rd_ok    <= 1'b0;
      resume_addr <= UNDEF_PAT;
      resume_ok   <= 1'b0;
      resume_go   <= 1'b0;
    end else begin
      pc_rd_ok   <= (st_nxt == TRK_FRESH);
      pc_rd_data <= (st_nxt == TRK_FRESH) ? pc_nxt : UNDEF_PAT;
      resume_go  <= !running && restart_req;
      if (!running && restart_req) begin
        resume_ok   <= (st_eff == TRK_PCSET);
        resume_addr <= (st_eff == TRK_PCSET) ? pc_eff : UNDEF_PAT;
      end
    end
  end

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resume_go |=> !resume_go); // R10
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (halted && restart_req) |=> (!halted && !pc_rd_ok && resume_go)); // R10
  AST_PCWR_HIDES_READ: assert property (@(posedge clk) disable iff (rst)
    (halted && (dbg_pc_wr || fpc_wr || dbg_st_wr)) |=> !pc_rd_ok); // R5
  AST_RUN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (!halted && !entry) |=> (!pc_rd_ok && !halted)); // R11
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (halted && !dbg_pc_wr && !fpc_wr && !dbg_st_wr && !restart_req)
      |=> ($stable(pc_rd_data) && $stable(pc_rd_ok))); // R4
endmodule

// File: tb/dbg_pc_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_pc_ctrl_tb;
  localparam logic [31:0] BEEF = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_req = 0, prev_compact = 0, dbg_pc_wr = 0, dbg_st_wr = 0;
  logic        fpc_wr = 0, fpc_cond_ok = 0, restart_req = 0;
  logic [2:0]  entry_kind = '0;
  logic [31:0] entry_ret_addr = '0, entry_vec_addr = '0, run_status = '0;
  logic [31:0] dbg_pc_data = '0, dbg_st_data = '0, fpc_data = '0;
  logic        halted, pc_rd_ok, resume_ok, resume_go;
  logic [31:0] pc_rd_data, status_rd, resume_addr;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_halt, m_rd, m_res, m_go, m_lok;
  logic [31:0] m_pc, m_st, m_laddr;

  always #2.5 clk = ~clk;

  dbg_pc_ctrl u_dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .entry_kind(entry_kind),
    .prev_compact(prev_compact), .entry_ret_addr(entry_ret_addr),
    .entry_vec_addr(entry_vec_addr), .run_status(run_status),
    .dbg_pc_wr(dbg_pc_wr), .dbg_pc_data(dbg_pc_data), .dbg_st_wr(dbg_st_wr),
    .dbg_st_data(dbg_st_data), .fpc_wr(fpc_wr), .fpc_cond_ok(fpc_cond_ok),
    .fpc_data(fpc_data), .restart_req(restart_req), .halted(halted),
    .pc_rd_data(pc_rd_data), .pc_rd_ok(pc_rd_ok), .status_rd(status_rd),
    .resume_addr(resume_addr), .resume_ok(resume_ok), .resume_go(resume_go)
  );

  task automatic model_edge();
    if (rst) begin
      m_halt = 0; m_rd = 0; m_res = 0; m_go = 0; m_lok = 0;
      m_pc = '0; m_st = '0; m_laddr = BEEF;
    end else if (!m_halt) begin
      m_go = 0;
      m_st = run_status;
      if (halt_req && entry_kind <= 3'd4) begin
        m_halt = 1;
        m_pc = ((entry_kind == 3'd0) ? entry_vec_addr : entry_ret_addr)
               + (prev_compact ? 32'd4 : 32'd8);
        m_rd = 1; m_res = 0;
      end
    end else begin
      m_go = 0;
      if (dbg_st_wr) begin m_st = dbg_st_data; m_rd = 0; m_res = 0; end
      if (dbg_pc_wr) begin m_pc = dbg_pc_data; m_rd = 0; m_res = 1; end
      if (fpc_wr) begin
        m_rd = 0;
        if (fpc_cond_ok) begin m_pc = fpc_data; m_res = 1; end
        else m_res = 0;
      end
      if (restart_req) begin
        m_go = 1; m_lok = m_res; m_laddr = m_res ? m_pc : BEEF;
        m_halt = 0; m_rd = 0; m_res = 0;
      end
    end
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("halted", 32'(halted), 32'(m_halt));
    chk("pc_rd_ok", 32'(pc_rd_ok), 32'(m_rd));
    chk("pc_rd_data", pc_rd_data, m_rd ? m_pc : BEEF);
    chk("status_rd", status_rd, m_st);
    chk("resume_ok", 32'(resume_ok), 32'(m_lok));
    chk("resume_addr", resume_addr, m_laddr);
    chk("resume_go", 32'(resume_go), 32'(m_go));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic clear();
    halt_req = 0; dbg_pc_wr = 0; dbg_st_wr = 0; fpc_wr = 0;
    fpc_cond_ok = 0; restart_req = 0;
  endtask

  task automatic idle(int n);
    clear();
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic enter(logic [2:0] k, logic cmp, logic [31:0] ra, logic [31:0] va);
    clear();
    halt_req = 1; entry_kind = k; prev_compact = cmp;
    entry_ret_addr = ra; entry_vec_addr = va;
    step();
    clear();
  endtask

  task automatic release_core();
    clear(); restart_req = 1; step(); clear(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset
    cur_req = "R1";
    step(); step();
    rst = 0;
    step();
    // R9 status tracking while running
    cur_req = "R9";
    run_status = 32'h0000_01F3; step();
    run_status = 32'h2000_0030; step();
    // R2 entries of several kinds
    cur_req = "R2";
    enter(3'd1, 1'b0, 32'h0000_1000, 32'h0);
    cur_req = "R4"; run_status = 32'h1111_1111; idle(4);
    cur_req = "R6"; release_core();
    cur_req = "R2";
    enter(3'd3, 1'b1, 32'h0000_2222, 32'h0);
    cur_req = "R6"; release_core();
    cur_req = "R2";
    enter(3'd2, 1'b0, 32'hFFFF_FFFC, 32'h0);
    release_core();
    enter(3'd4, 1'b1, 32'h0000_8000, 32'h0);
    release_core();
    // R3 vector catch and reserved kinds
    cur_req = "R3";
    enter(3'd0, 1'b0, 32'h0000_4444, 32'h0000_0018);
    release_core();
    enter(3'd0, 1'b1, 32'h0000_4444, 32'h0000_000C);
    release_core();
    for (int k = 5; k < 8; k++) begin
      enter(3'(k), 1'b0, 32'h0000_5555, 32'h0000_0010);
      idle(1);
    end
    // R5 debugger PC write then restart
    cur_req = "R5";
    enter(3'd1, 1'b0, 32'h0000_3000, 32'h0);
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_2000; step(); clear();
    idle(2);
    release_core();
    // R7 status write then restart: undefined
    cur_req = "R7";
    enter(3'd2, 1'b0, 32'h0000_3100, 32'h0);
    dbg_st_wr = 1; dbg_st_data = 32'h6000_01D3; step(); clear();
    idle(2);
    release_core();
    // R7 PC write, then status write, then restart: undefined
    enter(3'd2, 1'b0, 32'h0000_3200, 32'h0);
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_7000; step(); clear();
    dbg_st_wr = 1; dbg_st_data = 32'h0000_0010; step(); clear();
    release_core();
    // R7 status write then PC write: defined
    enter(3'd2, 1'b1, 32'h0000_3300, 32'h0);
    dbg_st_wr = 1; dbg_st_data = 32'hA5A5_0000; step(); clear();
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_7700; step(); clear();
    release_core();
    // R8 forced PC writes
    cur_req = "R8";
    enter(3'd1, 1'b0, 32'h0000_4000, 32'h0);
    fpc_wr = 1; fpc_cond_ok = 1; fpc_data = 32'h0000_9000; step(); clear();
    release_core();
    enter(3'd1, 1'b0, 32'h0000_4100, 32'h0);
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_9100; step(); clear();
    fpc_wr = 1; fpc_cond_ok = 0; fpc_data = 32'h0000_9200; step(); clear();
    idle(1);
    release_core();
    // R10 / R11 strobes while running, halt while halted
    cur_req = "R11";
    dbg_pc_wr = 1; dbg_pc_data = 32'h1234_5678; dbg_st_wr = 1;
    dbg_st_data = 32'hFFFF_0000; fpc_wr = 1; fpc_cond_ok = 1; restart_req = 1;
    step(); clear(); step();
    enter(3'd4, 1'b0, 32'h0000_5000, 32'h0);
    enter(3'd1, 1'b1, 32'h0000_6000, 32'h0);
    idle(1);
    cur_req = "R10";
    release_core();
    enter(3'd1, 1'b1, 32'h0000_6000, 32'h0);
    idle(1);
    // R11 same-cycle combinations with restart
    cur_req = "R11";
    dbg_st_wr = 1; dbg_st_data = 32'h0000_00AA; dbg_pc_wr = 1;
    dbg_pc_data = 32'h0000_ABC0; restart_req = 1; step(); clear(); step();
    enter(3'd3, 1'b0, 32'h0000_7000, 32'h0);
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_ABD0; fpc_wr = 1; fpc_cond_ok = 0;
    restart_req = 1; step(); clear(); step();
    enter(3'd3, 1'b0, 32'h0000_7100, 32'h0);
    dbg_pc_wr = 1; dbg_pc_data = 32'h0000_ABE0; fpc_wr = 1; fpc_cond_ok = 1;
    fpc_data = 32'h0000_ABF0; step(); clear();
    restart_req = 1; step(); clear(); step();
    // R1 reset while halted
    cur_req = "R1";
    enter(3'd1, 1'b0, 32'h0000_8800, 32'h0);
    rst = 1; step(); rst = 0; step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule